// File: doc/BRIEF.md
# NAND Flash Host Bus Bridge

This block sits between a simple word-wide host bus and the pins of one or two NAND flash dies. The host chooses the kind of flash cycle through its address. One address bit makes the access a command latch cycle. Another makes it an address latch cycle. With neither set, the access is a plain data transfer. A host access of one, two or four bytes is split into as many byte or halfword strobes as the flash bus width requires. Lanes are issued lowest first, and read lanes are packed back into one host word.

A further address bit steers the access to the second die of a multichip package. Each die has its own bus-width input, which selects an 8-bit or a 16-bit flash data bus. A separate address bit selects a status word instead of a flash cycle. Bit 0 of that word reports the synchronised state of the shared ready/busy line.

The setup, strobe-low and hold times are fixed parameters counted in clock cycles. The host holds its request until the single-cycle acknowledge arrives, so the host stalls until the last flash strobe has finished.

Top module: `nand_host_bridge`

## Requirements
- R1: A flash access with host address bit 4 set drives CLE high and ALE low for every strobe of that access.
- R2: A flash access with address bit 3 set and bit 4 clear drives ALE high and CLE low for every strobe.
- R3: When address bits 4 and 3 are both set, CLE wins and ALE stays low; CLE and ALE are never high together.
- R4: A flash access with address bits 4 and 3 both clear is a data cycle, with CLE and ALE low.
- R5: On an 8-bit flash bus, host size 0 (byte), 1 (halfword) and 2 or 3 (word) give 1, 2 and 4 strobes. Strobe k carries host byte k on data bits 7:0, and bits 15:8 are zero.
- R6: On a 16-bit flash bus, a word access gives 2 strobes carrying host halfword 0 and then halfword 1. Byte and halfword accesses give one strobe carrying host bits 15:0.
- R7: A read assembles the value sampled in the last strobe-low cycle of each beat into the host word, lowest lane first. Host bits above the beats collected read zero.
- R8: Host address bits 1:0 (and bits 2 and 7) have no effect on the pin sequence.
- R9: Address bit 5 clear selects die 0 (chip enable 0 low). Set, it selects die 1 (chip enable 1 low). At most one chip enable is low at a time. Bus width comes from the width input of the selected die (1 = 16 bits).
- R10: A host read with address bit 6 set returns the ready/busy line, passed through the synchroniser, in bit 0 and zero above. It produces no strobe and no chip enable.
- R11: Each strobe stays low exactly PULSE_CYC cycles, and the write and read strobes are never low together. Latch lines and write data stay stable while a strobe is low. A strobe falls SETUP_CYC cycles after its beat starts.
- R12: The acknowledge is a one-cycle pulse. It arrives beats×(SETUP_CYC+PULSE_CYC+HOLD_CYC) cycles after the request is taken, or in the next cycle for a status read. All chip enables are high and both strobes are high when it is given and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hreq | input | 1 | Host request, held until hack |
| hwr | input | 1 | 1 = write, 0 = read |
| haddr | input | AW | Host byte address (cycle type, die, status select) |
| hsize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| hwdata | input | HDW | Host write data |
| hrdata | output | HDW | Host read data, valid with hack |
| hack | output | 1 | One-cycle acknowledge |
| bus16 | input | 2 | Per-die bus width, 1 = 16-bit |
| nf_ce_n | output | 2 | Chip enables, active low, one per die |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | NDW | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_in | input | NDW | Flash data in |
| nf_rb | input | 1 | Shared ready/busy line (1 = ready) |

## Verification
Directed accesses separate the four cycle types: command bit alone, address bit alone, both bits, and neither. They also cover each host size on an 8-bit and a 16-bit bus, and show that stray low address bits leave the pin sequence unchanged. Reads return a distinct pattern on every strobe, so a swapped, repeated or misplaced lane shows up in the assembled word. Die 0 and die 1 are set to different bus widths, so a wrong die choice shows as a wrong strobe count as well as a wrong chip enable. Random accesses mix all of these with status reads while the ready line toggles. Each access is checked for strobe count, strobe width, latch levels, lane data and acknowledge latency.

// File: rtl/nhb_pkg.sv
package nhb_pkg;
  typedef enum logic [1:0] {
    CYC_DATA = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2
  } cyc_kind_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;
endpackage

// File: rtl/nhb_decode.sv
module nhb_decode
  import nhb_pkg::*;
#(
  parameter int AW       = 8,
  parameter int CLE_BIT  = 4,
  parameter int ALE_BIT  = 3,
  parameter int DIE_BIT  = 5,
  parameter int STAT_BIT = 6
) (
  input  logic [AW-1:0] addr,
  output cyc_kind_t     kind,
  output logic          die,
  output logic          stat
);
  always_comb begin
    stat = addr[STAT_BIT];
    die  = addr[DIE_BIT];
    // command latch outranks address latch
    if (addr[CLE_BIT])      kind = CYC_CMD;
    else if (addr[ALE_BIT]) kind = CYC_ADDR;
    else                    kind = CYC_DATA;
  end
endmodule

// File: rtl/nhb_lanes.sv
module nhb_lanes #(
  parameter int HDW = 32,
  parameter int NDW = 16,
  parameter int BW  = 3
) (
  input  logic           wide,
  input  logic [1:0]     size,
  input  logic [HDW-1:0] data,
  output logic [BW-1:0]  beats,
  output logic [NDW-1:0] lane
);
  localparam int HB = NDW / 2;

  always_comb begin
    case (size)
      2'd0:    beats = BW'(1);
      2'd1:    beats = wide ? BW'(1) : BW'(2);
      default: beats = wide ? BW'(HDW / NDW) : BW'(HDW / HB);
    endcase
    lane = wide ? data[NDW-1:0] : {{HB{1'b0}}, data[HB-1:0]};
  end
endmodule

// File: rtl/nhb_sync.sv
module nhb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/nhb_phase.sv
module nhb_phase
  import nhb_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int BW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [BW-1:0] beats,
  output logic          busy,
  output logic          we_n,
  output logic          re_n,
  output logic          cap,
  output logic          adv,
  output logic          done
);
  localparam int M1 = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MX = (M1 > HOLD_CYC) ? M1 : HOLD_CYC;
  localparam int CW = $clog2(MX + 1);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [BW-1:0] left;
  logic          wr_q;
  logic          last;

  always_comb begin
    last = (cnt == '0);
    busy = (ph != PH_IDLE);
    cap  = (ph == PH_PULSE) && last && !wr_q;
    adv  = (ph == PH_HOLD) && last && (left != '0);
    done = (ph == PH_HOLD) && last && (left == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      left <= '0;
      wr_q <= 1'b0;
      we_n <= 1'b1;
      re_n <= 1'b1;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph   <= PH_SETUP;
            cnt  <= CW'(SETUP_CYC - 1);
            left <= beats - BW'(1);
            wr_q <= wr;
          end
        end
        PH_SETUP: begin
          if (last) begin
            ph  <= PH_PULSE;
            cnt <= CW'(PULSE_CYC - 1);
            if (wr_q) we_n <= 1'b0;
            else      re_n <= 1'b0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_PULSE: begin
          if (last) begin
            ph   <= PH_HOLD;
            cnt  <= CW'(HOLD_CYC - 1);
            we_n <= 1'b1;
            re_n <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_HOLD: begin
          if (last) begin
            if (left == '0) begin
              ph <= PH_IDLE;
            end else begin
              left <= left - BW'(1);
              ph   <= PH_SETUP;
              cnt  <= CW'(SETUP_CYC - 1);
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
  import nhb_pkg::*;
#(
  parameter int AW          = 8,
  parameter int CLE_BIT     = 4,
  parameter int ALE_BIT     = 3,
  parameter int DIE_BIT     = 5,
  parameter int STAT_BIT    = 6,
  parameter int HDW         = 32,
  parameter int NDW         = 16,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hreq,
  input  logic           hwr,
  input  logic [AW-1:0]  haddr,
  input  logic [1:0]     hsize,
  input  logic [HDW-1:0] hwdata,
  output logic [HDW-1:0] hrdata,
  output logic           hack,
  input  logic [1:0]     bus16,
  output logic [1:0]     nf_ce_n,
  output logic           nf_cle,
  output logic           nf_ale,
  output logic           nf_we_n,
  output logic           nf_re_n,
  output logic [NDW-1:0] nf_dq_out,
  output logic           nf_dq_oe,
  input  logic [NDW-1:0] nf_dq_in,
  input  logic           nf_rb
);
  localparam int NDIE = 2;
  localparam int HB   = NDW / 2;
  localparam int BW   = $clog2(HDW / HB + 1);

  cyc_kind_t      kind;
  logic           die, stat, wide_now, rb_s;
  logic [BW-1:0]  beats;
  logic [NDW-1:0] lane0, lane_nxt;
  logic           busy, cap, adv, done, acc;
  logic [HDW-1:0] shreg, rbuf, rd_part;
  logic           wide_q, wr_q;
  logic [BW-1:0]  ridx;

  nhb_decode #(
    .AW(AW), .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT),
    .DIE_BIT(DIE_BIT), .STAT_BIT(STAT_BIT)
  ) u_dec (
    .addr(haddr), .kind(kind), .die(die), .stat(stat)
  );

  assign wide_now = bus16[die];

  nhb_lanes #(.HDW(HDW), .NDW(NDW), .BW(BW)) u_lanes (
    .wide(wide_now), .size(hsize), .data(hwdata), .beats(beats), .lane(lane0)
  );

  nhb_sync #(.STAGES(SYNC_STAGES)) u_rb (
    .clk(clk), .rst(rst), .d(nf_rb), .q(rb_s)
  );

  assign acc = hreq && !hack && !busy;

  nhb_phase #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC), .BW(BW)
  ) u_phase (
    .clk(clk), .rst(rst), .start(acc && !stat), .wr(hwr), .beats(beats),
    .busy(busy), .we_n(nf_we_n), .re_n(nf_re_n), .cap(cap), .adv(adv), .done(done)
  );

  always_comb begin
    lane_nxt = wide_q ? shreg[NDW-1:0] : {{HB{1'b0}}, shreg[HB-1:0]};
    if (wide_q) rd_part = HDW'(nf_dq_in) << (ridx * NDW);
    else        rd_part = HDW'(nf_dq_in[HB-1:0]) << (ridx * HB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hack      <= 1'b0;
      hrdata    <= '0;
      nf_ce_n   <= '1;
      nf_cle    <= 1'b0;
      nf_ale    <= 1'b0;
      nf_dq_out <= '0;
      nf_dq_oe  <= 1'b0;
      shreg     <= '0;
      wide_q    <= 1'b0;
      wr_q      <= 1'b0;
      ridx      <= '0;
      rbuf      <= '0;
    end else begin
      hack <= 1'b0;
      if (acc && stat) begin
        hack   <= 1'b1;
        hrdata <= {{(HDW-1){1'b0}}, rb_s};
      end else if (acc) begin
        nf_ce_n   <= ~(NDIE'(1) << die);
        nf_cle    <= (kind == CYC_CMD);
        nf_ale    <= (kind == CYC_ADDR);
        nf_dq_out <= hwr ? lane0 : '0;
        nf_dq_oe  <= hwr;
        shreg     <= hwdata >> (wide_now ? NDW : HB);
        wide_q    <= wide_now;
        wr_q      <= hwr;
        ridx      <= '0;
        rbuf      <= '0;
      end
      if (adv) begin
        nf_dq_out <= wr_q ? lane_nxt : '0;
        shreg     <= shreg >> (wide_q ? NDW : HB);
      end
      if (cap) begin
        rbuf <= rbuf | rd_part;
        ridx <= ridx + BW'(1);
      end
      if (done) begin
        hack      <= 1'b1;
        hrdata    <= wr_q ? '0 : rbuf;
        nf_ce_n   <= '1;
        nf_cle    <= 1'b0;
        nf_ale    <= 1'b0;
        nf_dq_out <= '0;
        nf_dq_oe  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nhb_checker.sv
module nhb_checker #(
  parameter int PULSE_CYC = 3,
  parameter int NDW       = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           hack,
  input logic [1:0]     nf_ce_n,
  input logic           nf_cle,
  input logic           nf_ale,
  input logic           nf_we_n,
  input logic           nf_re_n,
  input logic [NDW-1:0] nf_dq_out
);
  logic        lo;
  logic [15:0] lo_cnt;

  assign lo = !nf_we_n || !nf_re_n;

  always_ff @(posedge clk) begin
    if (rst)     lo_cnt <= '0;
    else if (lo) lo_cnt <= lo_cnt + 16'd1;
    else         lo_cnt <= '0;
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    hack |=> !hack); // R12

  AST_IDLE_AT_ACK: assert property (@(posedge clk) disable iff (rst)
    hack |-> (nf_ce_n == 2'b11) && nf_we_n && nf_re_n); // R12

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale)); // R3

  AST_ONE_DIE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~nf_ce_n)); // R9

  AST_STROBE_HAS_DIE: assert property (@(posedge clk) disable iff (rst)
    lo |-> (nf_ce_n != 2'b11)); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!nf_we_n && !nf_re_n)); // R11

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!lo && $past(lo)) |-> (lo_cnt == 16'(PULSE_CYC))); // R11

  AST_STABLE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!nf_we_n && $past(!nf_we_n)) |->
      ($stable(nf_dq_out) && $stable(nf_cle) && $stable(nf_ale))); // R11
endmodule

bind nand_host_bridge nhb_checker #(.PULSE_CYC(PULSE_CYC), .NDW(NDW)) u_nhb_chk (
  .clk(clk), .rst(rst), .hack(hack), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
  .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out)
);

// File: tb/nand_host_bridge_test.sv
module nand_host_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int S_C = 2;
  localparam int P_C = 3;
  localparam int H_C = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hreq = 1'b0, hwr = 1'b0;
  logic [7:0]  haddr = '0;
  logic [1:0]  hsize = '0;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata;
  logic        hack;
  logic [1:0]  bus16 = 2'b00;
  logic [1:0]  nf_ce_n;
  logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [15:0] nf_dq_out;
  logic [15:0] nf_dq_in = '0;
  logic        nf_rb = 1'b1;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  nand_host_bridge #(.SETUP_CYC(S_C), .PULSE_CYC(P_C), .HOLD_CYC(H_C)) uut (
    .clk(clk), .rst(rst), .hreq(hreq), .hwr(hwr), .haddr(haddr), .hsize(hsize),
    .hwdata(hwdata), .hrdata(hrdata), .hack(hack), .bus16(bus16),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
    .nf_dq_in(nf_dq_in), .nf_rb(nf_rb)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // pin monitor: one log entry per strobe
  int          rcount = 0;
  int          log_n = 0;
  bit          lo_now, lo_prev = 0;
  int          width = 0;
  bit          s_cle, s_ale, s_wr;
  logic [1:0]  s_ce;
  logic [15:0] s_dq;
  bit          l_cle [8];
  bit          l_ale [8];
  bit          l_wr  [8];
  logic [1:0]  l_ce  [8];
  logic [15:0] l_dq  [8];
  int          l_w   [8];

  function automatic logic [15:0] rpat(input int i);
    return 16'hA5C3 ^ 16'(i * 16'h1357);
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      lo_prev = 0;
      width = 0;
    end else begin
      lo_now = !nf_we_n || !nf_re_n;
      if (lo_now) begin
        if (!lo_prev) begin
          if (!nf_re_n) begin
            nf_dq_in = rpat(rcount);
            rcount++;
          end
          s_cle = nf_cle; s_ale = nf_ale; s_ce = nf_ce_n;
          s_dq = nf_dq_out; s_wr = !nf_we_n;
        end
        width++;
      end else if (lo_prev) begin
        if (log_n < 8) begin
          l_cle[log_n] = s_cle; l_ale[log_n] = s_ale; l_ce[log_n] = s_ce;
          l_dq[log_n] = s_dq; l_wr[log_n] = s_wr; l_w[log_n] = width;
        end
        log_n++;
        width = 0;
      end
      lo_prev = lo_now;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_beats(input bit wide, input logic [1:0] sz);
    if (sz == 2'd0) return 1;
    if (sz == 2'd1) return wide ? 1 : 2;
    return wide ? 2 : 4;
  endfunction

  function automatic logic [15:0] exp_lane(input bit wide, input logic [31:0] d, input int k);
    logic [31:0] s;
    s = wide ? (d >> (16 * k)) : (d >> (8 * k));
    return wide ? s[15:0] : {8'h00, s[7:0]};
  endfunction

  task automatic wait_ack(output int lat, output logic [31:0] got);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!hack && lat < 1000);
    got = hrdata;
    hreq = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] wd);
    bit          die, wide, ecle, eale;
    int          nb, lat, rb0;
    logic [31:0] got, exp;
    logic [1:0]  ece;
    string       kreq, wreq;
    die  = a[5];
    wide = bus16[die];
    nb   = exp_beats(wide, sz);
    ecle = a[4];
    eale = a[3] && !a[4];
    kreq = a[4] ? (a[3] ? "R3" : "R1") : (a[3] ? "R2" : "R4");
    wreq = wide ? "R6" : "R5";
    ece  = die ? 2'b01 : 2'b10;
    @(negedge clk);
    log_n = 0;
    rb0 = rcount;
    hreq = 1'b1; hwr = wr; haddr = a; hsize = sz; hwdata = wd;
    wait_ack(lat, got);
    chk(lat == nb * (S_C + P_C + H_C) + 1, "R12", "ack latency", lat, nb * (S_C + P_C + H_C) + 1);
    chk(log_n == nb, wreq, "strobe count", log_n, nb);
    for (int k = 0; k < nb && k < log_n && k < 8; k++) begin
      chk(l_cle[k] == ecle && l_ale[k] == eale, kreq, "latch levels",
          {l_cle[k], l_ale[k]}, {ecle, eale});
      chk(l_ce[k] == ece, "R9", "chip enable", l_ce[k], ece);
      chk(l_w[k] == P_C, "R11", "strobe width", l_w[k], P_C);
      chk(l_wr[k] == wr, "R11", "strobe kind", l_wr[k], wr);
      if (wr) chk(l_dq[k] == exp_lane(wide, wd, k), wreq, "write lane", l_dq[k], exp_lane(wide, wd, k));
    end
    if (!wr) begin
      exp = '0;
      for (int k = 0; k < nb; k++) begin
        if (wide) exp = exp | (32'(rpat(rb0 + k)) << (16 * k));
        else      exp = exp | (32'(rpat(rb0 + k) & 16'h00FF) << (8 * k));
      end
      chk(got == exp, "R7", "read word", got, exp);
    end
  endtask

  task automatic status_read(input logic lvl);
    int          lat;
    logic [31:0] got;
    nf_rb = lvl;
    repeat (4) @(negedge clk);
    log_n = 0;
    hreq = 1'b1; hwr = 1'b0; haddr = 8'h40; hsize = 2'd2;
    wait_ack(lat, got);
    chk(got == {31'b0, lvl}, "R10", "status word", got, {31'b0, lvl});
    chk(log_n == 0 && lat == 1, "R10", "status made strobes or waited", log_n, 0);
  endtask

  initial begin
    int f0;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(nf_ce_n == 2'b11 && nf_we_n && nf_re_n && !hack && !nf_cle && !nf_ale,
        "R12", "reset idle pins", {nf_ce_n, nf_we_n, nf_re_n, hack}, {2'b11, 1'b1, 1'b1, 1'b0});

    status_read(1'b0);
    status_read(1'b1);

    bus16 = 2'b10;                               // die0 8-bit, die1 16-bit
    access(1'b1, 8'h10, 2'd0, 32'h0000_0070);    // command
    access(1'b1, 8'h08, 2'd0, 32'h0000_0012);    // address
    access(1'b1, 8'h18, 2'd0, 32'h0000_0055);    // both bits: command wins
    access(1'b1, 8'h00, 2'd2, 32'hDEAD_BEEF);    // word on 8-bit bus
    access(1'b1, 8'h00, 2'd1, 32'h0000_C0DE);    // halfword on 8-bit bus
    access(1'b1, 8'h20, 2'd2, 32'h1234_5678);    // word on 16-bit bus, die 1
    access(1'b1, 8'h20, 2'd0, 32'h0000_ABCD);    // byte on 16-bit bus
    access(1'b0, 8'h00, 2'd2, 32'h0);            // read word, 8-bit
    access(1'b0, 8'h20, 2'd2, 32'h0);            // read word, 16-bit
    access(1'b0, 8'h00, 2'd1, 32'h0);            // read halfword, zero fill
    f0 = fails;
    access(1'b1, 8'h87, 2'd2, 32'hCAFE_F00D);    // stray low bits
    access(1'b0, 8'h0F, 2'd1, 32'h0);
    chk(fails == f0, "R8", "low address bits changed pin sequence", fails, f0);

    for (int i = 0; i < 80; i++) begin
      logic [7:0] a;
      bus16 = 2'($urandom);
      a = {1'b0, 1'b0, 3'($urandom), 3'($urandom)};
      if ($urandom % 8 == 0) status_read(1'($urandom));
      else access(1'($urandom), a, 2'($urandom), $urandom);
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL R12 watchdog: actual %0d expected below %0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule